// File: doc/BRIEF.md
# Compare-Instruction Length Decoder with Prefix Stall Detection

This block sits in front of a decode pipeline that receives instruction bytes one at a time. It supports a narrow slice of the x86-64 compare family. For each instruction it finds the last byte and emits one record holding:

- the total length in bytes;
- the opcode byte;
- the operand size;
- the immediate, sign-extended to 32 bits;
- two flags.

One flag marks a length-changing prefix. This is the case where the 0x66 operand-size prefix shrinks the immediate that follows opcode 0x3D from four bytes to two. Front ends that pre-decode lengths stall on that case, so downstream logic uses the flag to count or schedule around it. The other flag marks an opcode or ModRM form the block does not support.

Bytes arrive on a valid/ready stream. The record appears combinationally in the same cycle the instruction's final byte is accepted. The decoder is greedy. Once it has seen an opcode, it takes the following bytes as immediate whatever their value, even bytes that were meant to begin the next instruction.

Top module: `ild_cmp_decoder`

## Requirements
- R1: A synchronous active-high reset discards any partly collected instruction and returns the decoder to expecting a first byte. in_ready is 0 during reset and 1 from the first clock edge after reset is released.
- R2: Opcode 0x3D without prefix yields a 5-byte record. The immediate is the next four bytes in little-endian order, rec_osz16=0 (32-bit operand size), rec_lcp=0 and rec_unsup=0.
- R3: Bytes 0x66 0x3D yield a 4-byte record. The immediate is the next two bytes in little-endian order, sign-extended from bit 15, with rec_osz16=1 and rec_lcp=1. For example, 66 3D FB FF gives imm 0xFFFFFFFB.
- R4: Opcode 0x83 followed by a ModRM byte with mod=11 (bits 7:6) and reg=7 (bits 5:3) takes one immediate byte, sign-extended from bit 7. The record is 3 bytes long, or 4 with a 0x66 prefix. rec_osz16 follows the prefix and rec_lcp=0. For example, 66 83 F8 FB gives length 4 and imm 0xFFFFFFFB.
- R5: After an opcode, the required number of immediate bytes is consumed regardless of their value, including 0x66, 0x3D or 0x83.
- R6: A byte in the opcode position other than 0x3D or 0x83 ends the instruction at once. This includes a second 0x66. The record has rec_unsup=1, rec_imm=0 and rec_lcp=0, and its length counts the prefix and the opcode. The next byte starts a new instruction.
- R7: After 0x83, a ModRM byte that is not mod=11 with reg=7 ends the instruction at once. The record has rec_unsup=1, rec_imm=0 and rec_lcp=0, and its length includes the ModRM byte.
- R8: rec_valid is 1 only in a cycle where in_valid and in_ready are both 1 and the byte accepted is the final byte of an instruction. Exactly one record is produced per instruction.
- R9: A cycle with in_valid=0 consumes no byte and leaves the decode progress unchanged.
- R10: rec_opcode reports the opcode byte, never the prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte on in_byte is offered |
| in_byte | input | 8 | Instruction stream byte |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| rec_valid | output | 1 | A record is presented this cycle |
| rec_len | output | 4 | Instruction length in bytes |
| rec_opcode | output | 8 | Opcode byte of the instruction |
| rec_osz16 | output | 1 | 1 = 16-bit operand size (prefix seen), 0 = 32-bit |
| rec_imm | output | 32 | Immediate sign-extended to 32 bits |
| rec_lcp | output | 1 | Length-changing prefix event |
| rec_unsup | output | 1 | Unsupported opcode or ModRM form |

## Verification
A wrong internal phase shows on the very next record. The boundary moves, so rec_len is off and rec_valid fires one or more bytes early or late. Every later instruction in the stream is then framed wrongly until a record happens to realign. An error in the immediate lane index or byte count corrupts rec_imm or its sign extension on the record that closes the instruction. A lost prefix flips rec_osz16 and rec_lcp on that same record. The checks therefore compare every byte's rec_valid as well as each record's fields. Stall cycles are interleaved to expose state that changes without an accepted byte.

// File: rtl/ild_pkg.sv
package ild_pkg;

    typedef enum logic [1:0] {
        ST_PREFIX = 2'd0,
        ST_OPCODE = 2'd1,
        ST_MODRM  = 2'd2,
        ST_IMM    = 2'd3
    } ild_state_e;

    localparam logic [7:0] BYTE_OSIZE_PFX   = 8'h66;
    localparam logic [7:0] BYTE_CMP_ACC     = 8'h3D;
    localparam logic [7:0] BYTE_ALU_IMM8    = 8'h83;
    localparam logic [2:0] MODRM_REG_CMP    = 3'd7;
    localparam logic [1:0] MODRM_MOD_DIRECT = 2'b11;

    localparam int IMM_BYTES_FULL  = 4;
    localparam int IMM_BYTES_HALF  = 2;
    localparam int IMM_BYTES_SHORT = 1;

endpackage

// File: rtl/ild_opcode_class.sv
module ild_opcode_class
    import ild_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic [BYTE_W-1:0] opc_byte,
    input  logic              has_pfx,
    output logic              is_acc_form,
    output logic              is_imm8_form,
    output logic [CNT_W-1:0]  imm_count,
    output logic              len_changes
);

    always_comb begin
        is_acc_form  = (opc_byte == BYTE_CMP_ACC);
        is_imm8_form = (opc_byte == BYTE_ALU_IMM8);
        if (is_acc_form) begin
            imm_count = has_pfx ? CNT_W'(IMM_BYTES_HALF) : CNT_W'(IMM_BYTES_FULL);
        end else if (is_imm8_form) begin
            imm_count = CNT_W'(IMM_BYTES_SHORT);
        end else begin
            imm_count = '0;
        end
        len_changes = is_acc_form && has_pfx;
    end

endmodule

// File: rtl/ild_modrm_check.sv
module ild_modrm_check
    import ild_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] modrm,
    output logic              is_cmp_direct
);

    logic [1:0] mod_f;
    logic [2:0] reg_f;

    always_comb begin
        mod_f         = modrm[7:6];
        reg_f         = modrm[5:3];
        is_cmp_direct = (mod_f == MODRM_MOD_DIRECT) && (reg_f == MODRM_REG_CMP);
    end

endmodule

// File: rtl/ild_imm_gather.sv
module ild_imm_gather #(
    parameter int BYTE_W  = 8,
    parameter int IMM_MAX = 4,
    parameter int CNT_W   = 3,
    parameter int IMM_W   = IMM_MAX * BYTE_W
) (
    input  logic [IMM_W-1:0]  acc_q,
    input  logic [CNT_W-1:0]  lane,
    input  logic [CNT_W-1:0]  total,
    input  logic [BYTE_W-1:0] data,
    output logic [IMM_W-1:0]  acc_d,
    output logic [IMM_W-1:0]  imm_sx
);

    logic sign_bit;

    always_comb begin
        sign_bit = 1'b0;
        for (int i = 0; i < IMM_MAX; i++) begin
            if (total == CNT_W'(i + 1)) begin
                sign_bit = acc_d[i*BYTE_W + BYTE_W - 1];
            end
        end
    end

    for (genvar g = 0; g < IMM_MAX; g++) begin : g_lane
        assign acc_d[g*BYTE_W +: BYTE_W] =
            (lane == CNT_W'(g)) ? data : acc_q[g*BYTE_W +: BYTE_W];
        assign imm_sx[g*BYTE_W +: BYTE_W] =
            (CNT_W'(g) < total) ? acc_d[g*BYTE_W +: BYTE_W] : {BYTE_W{sign_bit}};
    end

endmodule

// File: rtl/ild_cmp_decoder.sv
module ild_cmp_decoder
    import ild_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int LEN_W   = 4,
    parameter int IMM_MAX = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    output logic              rec_valid,
    output logic [LEN_W-1:0]  rec_len,
    output logic [BYTE_W-1:0] rec_opcode,
    output logic              rec_osz16,
    output logic [IMM_MAX*BYTE_W-1:0] rec_imm,
    output logic              rec_lcp,
    output logic              rec_unsup
);

    localparam int IMM_W = IMM_MAX * BYTE_W;
    localparam int CNT_W = $clog2(IMM_MAX + 1);

    typedef struct packed {
        ild_state_e         st;
        logic               up;
        logic               pfx;
        logic               lcp;
        logic [LEN_W-1:0]   len;
        logic [BYTE_W-1:0]  opc;
        logic [CNT_W-1:0]   total;
        logic [CNT_W-1:0]   lane;
        logic [IMM_W-1:0]   acc;
    } dec_state_t;

    dec_state_t q_q, q_d;

    logic             cls_acc, cls_imm8, cls_lcp, modrm_ok, accept;
    logic [CNT_W-1:0] cls_cnt;
    logic [IMM_W-1:0] acc_next, imm_full;
    logic [LEN_W-1:0] len_inc;

    ild_opcode_class #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_class (
        .opc_byte     (in_byte),
        .has_pfx      (q_q.pfx),
        .is_acc_form  (cls_acc),
        .is_imm8_form (cls_imm8),
        .imm_count    (cls_cnt),
        .len_changes  (cls_lcp)
    );

    ild_modrm_check #(.BYTE_W(BYTE_W)) u_modrm (
        .modrm         (in_byte),
        .is_cmp_direct (modrm_ok)
    );

    ild_imm_gather #(.BYTE_W(BYTE_W), .IMM_MAX(IMM_MAX), .CNT_W(CNT_W)) u_gather (
        .acc_q  (q_q.acc),
        .lane   (q_q.lane),
        .total  (q_q.total),
        .data   (in_byte),
        .acc_d  (acc_next),
        .imm_sx (imm_full)
    );

    assign accept  = in_valid && q_q.up;
    assign len_inc = q_q.len + LEN_W'(1);

    always_comb begin
        q_d        = q_q;
        q_d.up     = 1'b1;
        rec_valid  = 1'b0;
        rec_len    = len_inc;
        rec_opcode = q_q.opc;
        rec_osz16  = q_q.pfx;
        rec_imm    = '0;
        rec_lcp    = 1'b0;
        rec_unsup  = 1'b0;

        if (accept) begin
            q_d.len = len_inc;
            unique case (q_q.st)
                ST_PREFIX, ST_OPCODE: begin
                    if (q_q.st == ST_PREFIX && in_byte == BYTE_OSIZE_PFX) begin
                        q_d.pfx = 1'b1;
                        q_d.st  = ST_OPCODE;
                    end else begin
                        q_d.opc    = in_byte;
                        rec_opcode = in_byte;
                        if (cls_acc) begin
                            q_d.st    = ST_IMM;
                            q_d.total = cls_cnt;
                            q_d.lane  = '0;
                            q_d.acc   = '0;
                            q_d.lcp   = cls_lcp;
                        end else if (cls_imm8) begin
                            q_d.st = ST_MODRM;
                        end else begin
                            rec_valid = 1'b1;
                            rec_unsup = 1'b1;
                        end
                    end
                end
                ST_MODRM: begin
                    if (modrm_ok) begin
                        q_d.st    = ST_IMM;
                        q_d.total = CNT_W'(IMM_BYTES_SHORT);
                        q_d.lane  = '0;
                        q_d.acc   = '0;
                        q_d.lcp   = 1'b0;
                    end else begin
                        rec_valid = 1'b1;
                        rec_unsup = 1'b1;
                    end
                end
                ST_IMM: begin
                    q_d.acc  = acc_next;
                    q_d.lane = q_q.lane + CNT_W'(1);
                    if (q_q.lane + CNT_W'(1) == q_q.total) begin
                        rec_valid = 1'b1;
                        rec_imm   = imm_full;
                        rec_lcp   = q_q.lcp;
                    end
                end
                default: q_d.st = ST_PREFIX;
            endcase

            if (rec_valid) begin
                q_d.st    = ST_PREFIX;
                q_d.pfx   = 1'b0;
                q_d.lcp   = 1'b0;
                q_d.len   = '0;
                q_d.total = '0;
                q_d.lane  = '0;
                q_d.acc   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign in_ready = q_q.up;

    // R8: a record only on an accepted byte
    p_rec_on_accept_r8: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (in_valid && in_ready));

    // R3: the length-changing flag only on the prefixed accumulator form
    p_lcp_shape_r3: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_lcp) |->
            (rec_len == LEN_W'(4) && rec_osz16 && rec_opcode == BYTE_CMP_ACC && !rec_unsup));

    // R2: unprefixed accumulator form is five bytes long
    p_acc_len_r2: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_unsup && !rec_osz16 && rec_opcode == BYTE_CMP_ACC) |->
            (rec_len == LEN_W'(5) && !rec_lcp));

    // R4: one-byte immediate is sign-extended
    p_imm8_sext_r4: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_unsup && rec_opcode == BYTE_ALU_IMM8) |->
            (rec_imm[IMM_W-1:7] == '0 || rec_imm[IMM_W-1:7] == '1));

    // R6: unsupported records carry no immediate and no stall flag
    p_unsup_clean_r6: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_unsup) |-> (rec_imm == '0 && !rec_lcp));

    // R6: decoding restarts after every record
    p_restart_r6: assert property (@(posedge clk) disable iff (rst)
        rec_valid |=> (q_q.st == ST_PREFIX && q_q.len == '0));

    // R9: no accepted byte, no progress
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> ($stable(q_q.st) && $stable(q_q.len) && $stable(q_q.lane)));

    // R5: immediate collection stays inside its byte count
    p_lane_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (q_q.st == ST_IMM) |-> (q_q.total != '0 && q_q.lane < q_q.total));

endmodule

// File: tb/ild_cmp_decoder_test.sv
module ild_cmp_decoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready, rec_valid, rec_osz16, rec_lcp, rec_unsup;
    logic [3:0]  rec_len;
    logic [7:0]  rec_opcode;
    logic [31:0] rec_imm;

    ild_cmp_decoder uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .rec_valid(rec_valid), .rec_len(rec_len),
        .rec_opcode(rec_opcode), .rec_osz16(rec_osz16), .rec_imm(rec_imm),
        .rec_lcp(rec_lcp), .rec_unsup(rec_unsup)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [7:0]  ib [8];
    int          nb;
    logic [3:0]  e_len;
    logic [7:0]  e_opc;
    logic        e_osz, e_lcp, e_unsup;
    logic [31:0] e_imm;
    string       e_req;
    bit          allow_gaps = 1'b1;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] sx16(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] sx8(input logic [7:0] v);
        return {{24{v[7]}}, v};
    endfunction

    task automatic push(input logic [7:0] b, input bit last);
        if (allow_gaps && ($urandom % 4) == 0) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_byte  = 8'($urandom);
            #1;
            check(rec_valid == 1'b0, "R9 stall", 32'(rec_valid), 32'd0);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        #1;
        check(rec_valid == last, "R8 record timing", 32'(rec_valid), 32'(last));
        if (last && rec_valid) begin
            check(rec_len == e_len, {e_req, " len"}, 32'(rec_len), 32'(e_len));
            check(rec_opcode == e_opc, "R10 opcode", 32'(rec_opcode), 32'(e_opc));
            check(rec_osz16 == e_osz, {e_req, " osz"}, 32'(rec_osz16), 32'(e_osz));
            check(rec_imm == e_imm, {e_req, " imm"}, rec_imm, e_imm);
            check(rec_lcp == e_lcp, {e_req, " lcp"}, 32'(rec_lcp), 32'(e_lcp));
            check(rec_unsup == e_unsup, {e_req, " unsup"}, 32'(rec_unsup), 32'(e_unsup));
        end
        @(posedge clk);
    endtask

    task automatic send_instr();
        for (int i = 0; i < nb; i++) push(ib[i], i == nb - 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1;
        check(in_ready == 1'b0, "R1 ready low in reset", 32'(in_ready), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(in_ready == 1'b1, "R1 ready after reset", 32'(in_ready), 32'd1);
        check(rec_valid == 1'b0, "R1 no record after reset", 32'(rec_valid), 32'd0);
    endtask

    task automatic gen_random(input int kind);
        logic [7:0] op, m;
        bit p;
        p = 1'($urandom);
        case (kind)
            0: begin
                ib[0] = 8'h3D;
                for (int i = 1; i <= 4; i++) ib[i] = 8'($urandom);
                nb = 5; e_len = 4'd5; e_opc = 8'h3D; e_osz = 1'b0; e_lcp = 1'b0;
                e_unsup = 1'b0; e_imm = {ib[4], ib[3], ib[2], ib[1]}; e_req = "R2";
            end
            1: begin
                ib[0] = 8'h66; ib[1] = 8'h3D; ib[2] = 8'($urandom); ib[3] = 8'($urandom);
                nb = 4; e_len = 4'd4; e_opc = 8'h3D; e_osz = 1'b1; e_lcp = 1'b1;
                e_unsup = 1'b0; e_imm = sx16({ib[3], ib[2]}); e_req = "R3";
            end
            2: begin
                nb = 0;
                if (p) begin ib[0] = 8'h66; nb = 1; end
                ib[nb] = 8'h83; ib[nb+1] = 8'hF8 | 8'($urandom % 8); ib[nb+2] = 8'($urandom);
                e_imm = sx8(ib[nb+2]);
                nb = nb + 3; e_len = 4'(nb); e_opc = 8'h83; e_osz = p; e_lcp = 1'b0;
                e_unsup = 1'b0; e_req = "R4";
            end
            3: begin
                do op = 8'($urandom); while (op == 8'h66 || op == 8'h3D || op == 8'h83);
                nb = 0;
                if (p) begin ib[0] = 8'h66; nb = 1; end
                ib[nb] = op; nb = nb + 1;
                e_len = 4'(nb); e_opc = op; e_osz = p; e_lcp = 1'b0; e_unsup = 1'b1;
                e_imm = 32'd0; e_req = "R6";
            end
            default: begin
                do m = 8'($urandom); while (m[7:6] == 2'b11 && m[5:3] == 3'd7);
                nb = 0;
                if (p) begin ib[0] = 8'h66; nb = 1; end
                ib[nb] = 8'h83; ib[nb+1] = m; nb = nb + 2;
                e_len = 4'(nb); e_opc = 8'h83; e_osz = p; e_lcp = 1'b0; e_unsup = 1'b1;
                e_imm = 32'd0; e_req = "R7";
            end
        endcase
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        do_reset();

        // R3: 66 3D FB FF
        allow_gaps = 1'b0;
        ib[0] = 8'h66; ib[1] = 8'h3D; ib[2] = 8'hFB; ib[3] = 8'hFF; nb = 4;
        e_len = 4'd4; e_opc = 8'h3D; e_osz = 1'b1; e_lcp = 1'b1; e_unsup = 1'b0;
        e_imm = 32'hFFFF_FFFB; e_req = "R3";
        send_instr();

        // R4: 66 83 F8 FB
        ib[0] = 8'h66; ib[1] = 8'h83; ib[2] = 8'hF8; ib[3] = 8'hFB; nb = 4;
        e_len = 4'd4; e_opc = 8'h83; e_osz = 1'b1; e_lcp = 1'b0; e_unsup = 1'b0;
        e_imm = 32'hFFFF_FFFB; e_req = "R4";
        send_instr();

        // R5: 66 3D FB swallows the 66 of the next instruction
        ib[0] = 8'h66; ib[1] = 8'h3D; ib[2] = 8'hFB; ib[3] = 8'h66; nb = 4;
        e_len = 4'd4; e_opc = 8'h3D; e_osz = 1'b1; e_lcp = 1'b1; e_unsup = 1'b0;
        e_imm = 32'h0000_66FB; e_req = "R5";
        send_instr();
        ib[0] = 8'h83; ib[1] = 8'hF8; ib[2] = 8'hFB; nb = 3;
        e_len = 4'd3; e_opc = 8'h83; e_osz = 1'b0; e_lcp = 1'b0; e_unsup = 1'b0;
        e_imm = 32'hFFFF_FFFB; e_req = "R5";
        send_instr();

        // R5: opcode-like bytes inside a 32-bit immediate
        ib[0] = 8'h3D; ib[1] = 8'h66; ib[2] = 8'h3D; ib[3] = 8'h83; ib[4] = 8'hFF; nb = 5;
        e_len = 4'd5; e_opc = 8'h3D; e_osz = 1'b0; e_lcp = 1'b0; e_unsup = 1'b0;
        e_imm = 32'hFF83_3D66; e_req = "R5";
        send_instr();

        // R6: doubled prefix is unsupported
        ib[0] = 8'h66; ib[1] = 8'h66; nb = 2;
        e_len = 4'd2; e_opc = 8'h66; e_osz = 1'b1; e_lcp = 1'b0; e_unsup = 1'b1;
        e_imm = 32'd0; e_req = "R6";
        send_instr();

        // R7: 83 with register-direct reg=0
        ib[0] = 8'h83; ib[1] = 8'hC0; nb = 2;
        e_len = 4'd2; e_opc = 8'h83; e_osz = 1'b0; e_lcp = 1'b0; e_unsup = 1'b1;
        e_imm = 32'd0; e_req = "R7";
        send_instr();

        // R1: reset in the middle of an instruction
        push(8'h66, 1'b0);
        push(8'h3D, 1'b0);
        push(8'hFB, 1'b0);
        do_reset();
        ib[0] = 8'h83; ib[1] = 8'hF8; ib[2] = 8'h05; nb = 3;
        e_len = 4'd3; e_opc = 8'h83; e_osz = 1'b0; e_lcp = 1'b0; e_unsup = 1'b0;
        e_imm = 32'h0000_0005; e_req = "R1";
        send_instr();

        // Random mix with stall gaps
        allow_gaps = 1'b1;
        for (int k = 0; k < 600; k++) begin
            gen_random(int'($urandom % 5));
            send_instr();
        end

        @(negedge clk);
        in_valid = 1'b0;
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule